// File: doc/BRIEF.md
# Four-Lane Double-Edge Sample Serializer

This block is the digital output stage of a four-channel, 12-bit sampling front end. Once per sample period it takes one parallel word for each channel and sends each word bit by bit on its own serial lane. It sends the most significant bit first, and it sends 12 bits per sample period. Two clocks go out with the data. The bit clock has six periods per sample, so every lane changes on both of its edges. The frame clock has one period per sample, and its rising transition marks the first bit of each word.

The block runs from a single internal clock at twelve times the sample rate. Each internal cycle stands for one half-period of the bit clock. A shared two-bit select can replace the data on every lane with one of two fixed alignment patterns, and both clocks keep running while a pattern is selected. A power-down input turns off every lane driver and parks both clocks low. Releasing power-down starts a fresh word on the next cycle.

The controller has two states. In `ST_OFF` the outputs are disabled. In `ST_SHIFT` the lanes are driven. The transitions are:
- `ST_OFF` → `ST_SHIFT` when power-down is sampled low. The first word is loaded on that edge.
- `ST_SHIFT` → `ST_SHIFT`, the wrap transition, on bit count 11. The next word is reloaded on that edge.
- `ST_SHIFT` → `ST_OFF` whenever power-down is sampled high.

Top module: `adc_ddr_serializer`

## Requirements
- R1: Each lane carries its loaded word most significant bit first, one bit per internal cycle, 12 cycles per word. The MSB is present in the first cycle of the frame-clock high phase.
- R2: While enabled, `bit_clk` toggles on every internal cycle, giving six rising transitions per word. It is high in the first cycle of each word.
- R3: `frame_clk` is high for the first six cycles of each word and low for the last six.
- R4: Parallel words and the pattern select are sampled only on the edge that starts a word. A change to `din` in the middle of a word does not alter the word being sent, and the new value appears in the following word.
- R5: With `pat_sel` = 1 (01b), every lane sends 1000 0000 0000 (0x800).
- R6: With `pat_sel` = 2 (10b), every lane sends 1010 1010 1010 (0xAAA).
- R7: While a test pattern is selected, `bit_clk` and `frame_clk` run exactly as in normal operation and all lane enables stay high.
- R8: `pat_sel` = 3 (11b) is reserved. It sends the normal data and sets `sel_err`, which then stays high until reset.
- R9: From the cycle after `pd` is sampled high, all `lane_oe` bits are 0, all `lane_dat` bits are 0, and both clocks are low. This holds for as long as `pd` stays high.
- R10: In the cycle after `pd` is sampled low again, a new word starts. All enables are high, `frame_clk` and `bit_clk` are high, and the lanes carry the word that was on `din` at that edge.
- R11: During reset the lane enables, both clocks and `sel_err` are all 0. With `pd` low, the first word starts on the first clock edge after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock at twelve times the sample rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| pd | input | 1 | Power-down: disables all lanes and parks both clocks |
| pat_sel | input | 2 | 0 = data, 1 = single-one pattern, 2 = alternating pattern, 3 = reserved |
| din | input | NCH*W (48) | Parallel words; channel c occupies bits [c*W +: W] |
| lane_dat | output | NCH (4) | Serial data, one bit per lane |
| lane_oe | output | NCH (4) | Lane driver enables; 0 stands for high impedance |
| bit_clk | output | 1 | Bit clock, six periods per word |
| frame_clk | output | 1 | Frame clock, one period per word |
| sel_err | output | 1 | Sticky flag for the reserved select code |

## Verification
The assertions assume two things about the inputs: that `pd` and `pat_sel` are synchronous to `clk`, and that the parameter `W` is even, so that the frame clock can split into two equal halves. The bench drives every input on the falling clock edge and changes `din` or `pat_sel` only at points where the next capture edge is known. Before each captured frame the bench waits for an observed rising edge of `frame_clk`, so the edge that samples a new setting always comes after the change. It never requests a word in the same cycle it changes the data.

// File: rtl/adc_ser_pkg.sv
package adc_ser_pkg;

    typedef enum logic {
        ST_OFF,
        ST_SHIFT
    } ser_state_t;

    typedef enum logic [1:0] {
        SEL_DATA = 2'd0,
        SEL_ONE  = 2'd1,
        SEL_ALT  = 2'd2,
        SEL_RSVD = 2'd3
    } pat_sel_t;

endpackage

// File: rtl/ser_frame_ctrl.sv
module ser_frame_ctrl
    import adc_ser_pkg::*;
#(
    parameter int W = 12
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pd,
    output logic run,
    output logic load,
    output logic shift_en,
    output logic bit_clk,
    output logic frame_clk
);
    localparam int CW   = $clog2(W);
    localparam int HALF = W / 2;
    localparam logic [CW-1:0] LAST = CW'(W - 1);

    ser_state_t    st, st_nx;
    logic [CW-1:0] cnt;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_OFF;
        else        st <= st_nx;
    end

    always_comb begin
        st_nx = st;
        unique case (st)
            ST_OFF:   st_nx = pd ? ST_OFF : ST_SHIFT;
            ST_SHIFT: st_nx = pd ? ST_OFF : ST_SHIFT;
            default:  st_nx = ST_OFF;
        endcase
    end

    // bit position within the current word
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        cnt <= '0;
        else if (load)     cnt <= '0;
        else if (shift_en) cnt <= cnt + 1'b1;
        else               cnt <= '0;
    end

    // outputs
    always_comb begin
        run       = (st == ST_SHIFT);
        load      = !pd && ((st == ST_OFF) || (cnt == LAST));
        shift_en  = !pd && (st == ST_SHIFT) && (cnt != LAST);
        bit_clk   = run && !cnt[0];
        frame_clk = run && (int'(cnt) < HALF);
    end

endmodule

// File: rtl/ser_pattern_mux.sv
module ser_pattern_mux
    import adc_ser_pkg::*;
#(
    parameter int W   = 12,
    parameter int NCH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       sel,
    input  logic [NCH*W-1:0] din,
    output logic [NCH*W-1:0] word,
    output logic             err
);
    pat_sel_t     sel_t;
    logic [W-1:0] pat_one, pat_alt;

    always_comb begin
        sel_t   = pat_sel_t'(sel);
        pat_one = '0;
        pat_one[W-1] = 1'b1;
        for (int b = 0; b < W; b++) pat_alt[b] = (((W - 1 - b) % 2) == 0);
    end

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        always_comb begin
            unique case (sel_t)
                SEL_ONE: word[c*W +: W] = pat_one;
                SEL_ALT: word[c*W +: W] = pat_alt;
                default: word[c*W +: W] = din[c*W +: W];
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 err <= 1'b0;
        else if (sel_t == SEL_RSVD) err <= 1'b1;
    end

endmodule

// File: rtl/ser_lane.sv
module ser_lane #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         shift_en,
    input  logic [W-1:0] word,
    output logic         msb
);
    logic [W-1:0] sr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        sr <= '0;
        else if (load)     sr <= word;
        else if (shift_en) sr <= {sr[W-2:0], 1'b0};
    end

    assign msb = sr[W-1];

endmodule

// File: rtl/adc_ddr_serializer.sv
module adc_ddr_serializer #(
    parameter int W   = 12,
    parameter int NCH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pd,
    input  logic [1:0]       pat_sel,
    input  logic [NCH*W-1:0] din,
    output logic [NCH-1:0]   lane_dat,
    output logic [NCH-1:0]   lane_oe,
    output logic             bit_clk,
    output logic             frame_clk,
    output logic             sel_err
);
    logic             run, load, shift_en;
    logic [NCH*W-1:0] word;
    logic [NCH-1:0]   msb;

    ser_frame_ctrl #(.W(W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .pd(pd),
        .run(run), .load(load), .shift_en(shift_en),
        .bit_clk(bit_clk), .frame_clk(frame_clk)
    );

    ser_pattern_mux #(.W(W), .NCH(NCH)) u_mux (
        .clk(clk), .rst_n(rst_n), .sel(pat_sel), .din(din),
        .word(word), .err(sel_err)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_lane
        ser_lane #(.W(W)) u_lane (
            .clk(clk), .rst_n(rst_n), .load(load), .shift_en(shift_en),
            .word(word[c*W +: W]), .msb(msb[c])
        );
        assign lane_dat[c] = run & msb[c];
        assign lane_oe[c]  = run;
    end

endmodule

// File: rtl/ser_checker.sv
module ser_checker #(
    parameter int W   = 12,
    parameter int NCH = 4
) (
    input logic           clk,
    input logic           rst_n,
    input logic           pd,
    input logic [1:0]     pat_sel,
    input logic [NCH-1:0] lane_dat,
    input logic [NCH-1:0] lane_oe,
    input logic           bit_clk,
    input logic           frame_clk,
    input logic           sel_err
);
    localparam int HALF = W / 2;
    localparam int RW   = $clog2(W) + 1;

    logic [RW-1:0] fh_run;
    logic          on;

    assign on = (lane_oe != '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         fh_run <= '0;
        else if (frame_clk) fh_run <= fh_run + 1'b1;
        else                fh_run <= '0;
    end

    p_off_after_pd_r9: assert property (@(posedge clk) disable iff (!rst_n)
        pd |=> (lane_oe == '0 && lane_dat == '0 && !bit_clk && !frame_clk));

    p_wake_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!pd && !on) |=> (lane_oe == '1 && frame_clk && bit_clk));

    p_bitclk_toggle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (on && $past(on)) |-> (bit_clk != $past(bit_clk)));

    p_frame_bit_align_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(frame_clk) |-> $rose(bit_clk));

    p_frame_half_r3: assert property (@(posedge clk) disable iff (!rst_n)
        frame_clk |-> (int'(fh_run) < HALF));

    p_err_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (pat_sel == 2'd3) |=> sel_err);

    p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        sel_err |=> sel_err);

    p_oe_uniform_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (lane_oe == '0) || (lane_oe == '1));

endmodule

bind adc_ddr_serializer ser_checker #(.W(W), .NCH(NCH)) u_chk (
    .clk(clk), .rst_n(rst_n), .pd(pd), .pat_sel(pat_sel),
    .lane_dat(lane_dat), .lane_oe(lane_oe), .bit_clk(bit_clk),
    .frame_clk(frame_clk), .sel_err(sel_err)
);

// File: tb/adc_ddr_serializer_tb.sv
module adc_ddr_serializer_tb;
    localparam int W   = 12;
    localparam int NCH = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             pd = 1'b1;
    logic [1:0]       pat_sel = 2'd0;
    logic [NCH*W-1:0] din = '0;
    logic [NCH-1:0]   lane_dat, lane_oe;
    logic             bit_clk, frame_clk, sel_err;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    logic [W-1:0] cap [NCH];
    int           cap_rise, cap_fhigh, cap_tog_bad, cap_oe_bad;
    bit           mid_en = 0;
    bit           no_wait = 0;
    logic [NCH*W-1:0] mid_din = '0;

    always #10 clk = ~clk;

    adc_ddr_serializer #(.W(W), .NCH(NCH)) u_dut (
        .clk(clk), .rst_n(rst_n), .pd(pd), .pat_sel(pat_sel), .din(din),
        .lane_dat(lane_dat), .lane_oe(lane_oe), .bit_clk(bit_clk),
        .frame_clk(frame_clk), .sel_err(sel_err)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [NCH*W-1:0] pack(input logic [W-1:0] a, b, c, d);
        return {d, c, b, a};
    endfunction

    // collect one word per lane, starting at an observed frame start
    task automatic capture();
        logic pfc, pbc;
        cap_rise = 0; cap_fhigh = 0; cap_tog_bad = 0; cap_oe_bad = 0;
        for (int c = 0; c < NCH; c++) cap[c] = '0;
        if (!no_wait) begin
            pfc = frame_clk;
            forever begin
                @(negedge clk);
                if (frame_clk && !pfc) break;
                pfc = frame_clk;
            end
        end
        pbc = 1'b0;
        for (int i = 0; i < W; i++) begin
            if (i > 0) @(negedge clk);
            for (int c = 0; c < NCH; c++) cap[c] = {cap[c][W-2:0], lane_dat[c]};
            if (frame_clk && i < W / 2) cap_fhigh++;
            if (frame_clk && i >= W / 2) cap_fhigh += 100;
            if (bit_clk && !pbc) cap_rise++;
            if (i > 0 && bit_clk == pbc) cap_tog_bad++;
            if (lane_oe != '1) cap_oe_bad++;
            pbc = bit_clk;
            if (mid_en && i == 5) din = mid_din;
        end
        no_wait = 0;
    endtask

    task automatic expect_words(input logic [NCH*W-1:0] exp, input string req);
        for (int c = 0; c < NCH; c++)
            check(cap[c] == exp[c*W +: W], req, int'(cap[c]), int'(exp[c*W +: W]));
    endtask

    task automatic t_reset();
        @(negedge clk);
        check(lane_oe == '0, "R11 oe in reset", int'(lane_oe), 0);
        check(!bit_clk && !frame_clk, "R11 clocks in reset", int'({bit_clk, frame_clk}), 0);
        check(!sel_err, "R11 err in reset", int'(sel_err), 0);
        din = pack(12'h5A3, 12'h3C7, 12'hF01, 12'h0FE);
        pd = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        check(lane_oe == '1 && frame_clk && bit_clk, "R11 first word start",
              int'({lane_oe, frame_clk, bit_clk}), 'h3f);
        no_wait = 1;
        capture();
        expect_words(pack(12'h5A3, 12'h3C7, 12'hF01, 12'h0FE), "R11 R1 first word");
    endtask

    task automatic t_normal(input logic [NCH*W-1:0] v);
        @(negedge clk);
        din = v;
        capture();
        expect_words(v, "R1 lane word");
        check(cap_rise == 6, "R2 bit clock rises", cap_rise, 6);
        check(cap_tog_bad == 0, "R2 bit clock toggle", cap_tog_bad, 0);
        check(cap_fhigh == 6, "R3 frame high phase", cap_fhigh, 6);
    endtask

    task automatic t_midframe();
        logic [NCH*W-1:0] a, b;
        a = pack(12'hABC, 12'h123, 12'h800, 12'h001);
        b = pack(12'h456, 12'hFED, 12'h7FF, 12'hC3C);
        @(negedge clk);
        din = a;
        mid_din = b;
        mid_en = 1;
        capture();
        mid_en = 0;
        expect_words(a, "R4 word kept after mid-frame change");
        capture();
        expect_words(b, "R4 new word in next frame");
    endtask

    task automatic t_pattern(input logic [1:0] s, input logic [W-1:0] p, input string req);
        @(negedge clk);
        pat_sel = s;
        din = pack(12'h111, 12'h222, 12'h333, 12'h444);
        capture();
        expect_words(pack(p, p, p, p), req);
        check(cap_rise == 6 && cap_tog_bad == 0, "R7 bit clock in pattern", cap_rise, 6);
        check(cap_fhigh == 6, "R7 frame clock in pattern", cap_fhigh, 6);
        check(cap_oe_bad == 0, "R7 enables in pattern", cap_oe_bad, 0);
        pat_sel = 2'd0;
        capture();
    endtask

    task automatic t_reserved();
        logic [NCH*W-1:0] v;
        v = pack(12'h9E2, 12'h06D, 12'hB5B, 12'h310);
        @(negedge clk);
        check(!sel_err, "R8 err clear before", int'(sel_err), 0);
        pat_sel = 2'd3;
        din = v;
        capture();
        expect_words(v, "R8 reserved code sends data");
        check(sel_err, "R8 err set", int'(sel_err), 1);
        pat_sel = 2'd0;
        capture();
        capture();
        check(sel_err, "R8 err sticky", int'(sel_err), 1);
    endtask

    task automatic t_powerdown();
        logic [NCH*W-1:0] v;
        v = pack(12'hD2D, 12'h0F0, 12'h5A5, 12'hE07);
        capture();
        @(negedge clk);
        pd = 1'b1;
        @(negedge clk);
        check(lane_oe == '0, "R9 oe off", int'(lane_oe), 0);
        check(lane_dat == '0, "R9 data low", int'(lane_dat), 0);
        check(!bit_clk && !frame_clk, "R9 clocks parked", int'({bit_clk, frame_clk}), 0);
        repeat (20) @(negedge clk);
        check(lane_oe == '0 && !bit_clk && !frame_clk, "R9 stays off",
              int'({lane_oe, bit_clk, frame_clk}), 0);
        din = v;
        pd = 1'b0;
        @(negedge clk);
        check(lane_oe == '1, "R10 oe on", int'(lane_oe), 'hf);
        check(frame_clk && bit_clk, "R10 clocks restart", int'({frame_clk, bit_clk}), 3);
        no_wait = 1;
        capture();
        expect_words(v, "R10 word after wake");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_normal(pack(12'hFFF, 12'h000, 12'hFFF, 12'h000));
        t_normal(pack(12'h001, 12'h800, 12'h555, 12'hAAA));
        t_normal(pack(12'h7E1, 12'h19B, 12'hC64, 12'h2D8));
        t_midframe();
        t_pattern(2'd1, 12'h800, "R5 single-one pattern");
        t_pattern(2'd2, 12'hAAA, "R6 alternating pattern");
        t_reserved();
        t_powerdown();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule